// File: doc/BRIEF.md
# CAN Mailbox Receive Status Sequencer

This block keeps the receive-side status of a bank of sixteen CAN message slots. A frame-level front end drives it. That front end reports when a frame begins, and when it ends, whether the frame was accepted and which slot it matched. A separate strobe reports when the received payload has been written into that slot's storage. Per slot, the block holds four bits: an armed (receive-request) bit, a storing flag, a new-data flag and an interrupt request. Across the whole bank it holds a receiving-in-progress flag, a reception-succeeded flag and the number of the slot that most recently finished a reception.

Completion takes two steps. When an accepted frame ends on an armed slot, the block raises that slot's storing and new-data flags and the bank-wide success flag. When the storage write for that slot later finishes, the storing flag drops. Only then are the interrupt request raised and the slot number published. Software arms and disarms slots through a small select/data write port. The same port clears new-data and interrupt bits (write-one-to-clear) and clears the success flag.

Top module: `rxs_mbox_status`

## Requirements
- R1: Write select 0 sets the armed bit of every slot whose data bit is 1. Write select 1 clears the armed bit of every slot whose data bit is 1. Either change is visible on `req_o` one cycle after the write.
- R2: `frm_start` sets `receiving_o` on the next cycle. `frm_end` or `frm_err` clears it on the next cycle, and a clear takes priority over a start in the same cycle.
- R3: A completion is `frm_end`=1 with `frm_err`=0 and `frm_accept`=1 while the armed bit of `frm_slot` is 1. One cycle after a completion, bit `frm_slot` of `storing_o` and of `newdata_o` is 1 and `success_o` is 1. `irq_o` and `last_slot_o` do not change at that point.
- R4: A frame end with `frm_err`=1, or with `frm_accept`=0, or whose slot is not armed, changes no slot flag and does not change `success_o`.
- R5: `wr_done` for a slot `wr_slot` whose storing bit is 1 has three effects on the next cycle: it clears that storing bit, it sets bit `wr_slot` of `irq_o`, and it loads `last_slot_o` with `wr_slot`.
- R6: `wr_done` for a slot whose storing bit is 0 has no effect. `last_slot_o` changes only through R5.
- R7: Write select 2 clears new-data bits where the data bit is 1. Write select 3 clears interrupt bits where the data bit is 1. A hardware set of the same bit in the same cycle wins over the clear.
- R8: Write select 4 with data bit 0 equal to 0 clears `success_o`. With data bit 0 equal to 1 it has no effect. A completion in the same cycle wins over the clear.
- R9: The synchronous active-high `rst` clears every armed, storing, new-data and interrupt bit, `receiving_o`, `success_o` and `last_slot_o`.
- R10: A slot stays armed after it receives a frame, so it can accept further frames without being re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_start | input | 1 | A frame has begun on the bus |
| frm_end | input | 1 | The frame has ended |
| frm_err | input | 1 | The frame was aborted by an error |
| frm_accept | input | 1 | The ending frame passed acceptance |
| frm_slot | input | 4 | Slot matched by the ending frame |
| wr_done | input | 1 | The payload write into a slot has finished |
| wr_slot | input | 4 | Slot whose write finished |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 3 | Write select (0 arm, 1 disarm, 2 new-data clear, 3 interrupt clear, 4 success control) |
| sw_wdata | input | 16 | Write data, one bit per slot |
| req_o | output | 16 | Armed bits |
| storing_o | output | 16 | Storing-in-progress flags |
| newdata_o | output | 16 | New-data flags |
| irq_o | output | 16 | Interrupt requests |
| receiving_o | output | 1 | A frame is being received |
| success_o | output | 1 | A reception has succeeded |
| last_slot_o | output | 4 | Slot of the last finished reception |

## Verification
The assertions check on every cycle:
- how `receiving_o` follows frame start, end and error;
- that a storing flag only rises on a slot that was armed the cycle before;
- that a finished write publishes the interrupt and the slot number, and that a write to an idle slot leaves the number alone;
- that interrupt bits and the success flag drop only through their software clears.

Some behaviours can only be shown by the bench's scenarios, because they depend on what does not change:
- that rejected, errored and unarmed frames are ignored;
- that a hardware set wins over a software clear in the same cycle;
- that a slot stays armed across several receptions.

A reference model running beside the design covers long mixed traffic.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int NSLOT  = 16;
    localparam int SLOT_W = $clog2(NSLOT);

    typedef enum logic [2:0] {
        SEL_REQ_SET = 3'd0,
        SEL_REQ_CLR = 3'd1,
        SEL_NEW_CLR = 3'd2,
        SEL_IRQ_CLR = 3'd3,
        SEL_STAT    = 3'd4
    } sw_sel_e;

    typedef struct packed {
        logic [NSLOT-1:0] req_set;
        logic [NSLOT-1:0] req_clr;
        logic [NSLOT-1:0] new_clr;
        logic [NSLOT-1:0] irq_clr;
        logic             succ_clr;
    } sw_cmd_t;

    typedef struct packed {
        logic              start;
        logic              done;
        logic              err;
        logic              accept;
        logic [SLOT_W-1:0] slot;
    } frame_ev_t;

    function automatic logic [NSLOT-1:0] slot_onehot(input logic [SLOT_W-1:0] idx,
                                                      input logic en);
        logic [NSLOT-1:0] v;
        v = '0;
        if (en) v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rxs_sw_decode.sv
module rxs_sw_decode
    import rxs_pkg::*;
(
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [NSLOT-1:0] wdata,
    output sw_cmd_t          cmd
);
    always_comb begin
        cmd = '0;
        if (we) begin
            case (sel)
                SEL_REQ_SET: cmd.req_set  = wdata;
                SEL_REQ_CLR: cmd.req_clr  = wdata;
                SEL_NEW_CLR: cmd.new_clr  = wdata;
                SEL_IRQ_CLR: cmd.irq_clr  = wdata;
                SEL_STAT:    cmd.succ_clr = ~wdata[0];
                default:     cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/rxs_frame_track.sv
module rxs_frame_track
    import rxs_pkg::*;
#(
    parameter int N  = NSLOT,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  frame_ev_t     ev,
    input  logic [N-1:0]  armed,
    input  logic          succ_clr,
    output logic [N-1:0]  cmpl_vec,
    output logic          receiving,
    output logic          success
);
    logic hit;

    assign hit = ev.done & ~ev.err & ev.accept & armed[ev.slot[SW-1:0]];

    always_comb begin
        cmpl_vec = '0;
        if (hit) cmpl_vec[ev.slot[SW-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            receiving <= 1'b0;
        end else if (ev.done || ev.err) begin
            receiving <= 1'b0;
        end else if (ev.start) begin
            receiving <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            success <= 1'b0;
        end else if (hit) begin
            success <= 1'b1;
        end else if (succ_clr) begin
            success <= 1'b0;
        end
    end
endmodule

// File: rtl/rxs_release.sv
module rxs_release
    import rxs_pkg::*;
#(
    parameter int N  = NSLOT,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_done,
    input  logic [SW-1:0] wr_slot,
    input  logic [N-1:0]  storing,
    output logic [N-1:0]  rel_vec,
    output logic [SW-1:0] last_slot
);
    logic rel_hit;

    assign rel_hit = wr_done & storing[wr_slot];

    always_comb begin
        rel_vec = '0;
        if (rel_hit) rel_vec[wr_slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_slot <= '0;
        end else if (rel_hit) begin
            last_slot <= wr_slot;
        end
    end
endmodule

// File: rtl/rxs_slot_cell.sv
module rxs_slot_cell (
    input  logic clk,
    input  logic rst,
    input  logic req_set,
    input  logic req_clr,
    input  logic cmpl,
    input  logic rel,
    input  logic new_clr,
    input  logic irq_clr,
    output logic armed,
    output logic storing,
    output logic newdata,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            storing <= 1'b0;
            newdata <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (req_set)      armed <= 1'b1;
            else if (req_clr) armed <= 1'b0;

            if (cmpl)         storing <= 1'b1;
            else if (rel)     storing <= 1'b0;

            if (cmpl)         newdata <= 1'b1;
            else if (new_clr) newdata <= 1'b0;

            if (rel)          irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/rxs_mbox_status.sv
module rxs_mbox_status
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              frm_end,
    input  logic              frm_err,
    input  logic              frm_accept,
    input  logic [SLOT_W-1:0] frm_slot,
    input  logic              wr_done,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              sw_we,
    input  logic [2:0]        sw_sel,
    input  logic [NSLOT-1:0]  sw_wdata,
    output logic [NSLOT-1:0]  req_o,
    output logic [NSLOT-1:0]  storing_o,
    output logic [NSLOT-1:0]  newdata_o,
    output logic [NSLOT-1:0]  irq_o,
    output logic              receiving_o,
    output logic              success_o,
    output logic [SLOT_W-1:0] last_slot_o
);
    sw_cmd_t          cmd;
    frame_ev_t        ev;
    logic [NSLOT-1:0] cmpl_vec;
    logic [NSLOT-1:0] rel_vec;

    assign ev.start  = frm_start;
    assign ev.done   = frm_end;
    assign ev.err    = frm_err;
    assign ev.accept = frm_accept;
    assign ev.slot   = frm_slot;

    rxs_sw_decode u_dec (
        .we    (sw_we),
        .sel   (sw_sel),
        .wdata (sw_wdata),
        .cmd   (cmd)
    );

    rxs_frame_track #(.N(NSLOT)) u_frm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .armed     (req_o),
        .succ_clr  (cmd.succ_clr),
        .cmpl_vec  (cmpl_vec),
        .receiving (receiving_o),
        .success   (success_o)
    );

    rxs_release #(.N(NSLOT)) u_rel (
        .clk       (clk),
        .rst       (rst),
        .wr_done   (wr_done),
        .wr_slot   (wr_slot),
        .storing   (storing_o),
        .rel_vec   (rel_vec),
        .last_slot (last_slot_o)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        rxs_slot_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .req_set (cmd.req_set[s]),
            .req_clr (cmd.req_clr[s]),
            .cmpl    (cmpl_vec[s]),
            .rel     (rel_vec[s]),
            .new_clr (cmd.new_clr[s]),
            .irq_clr (cmd.irq_clr[s]),
            .armed   (req_o[s]),
            .storing (storing_o[s]),
            .newdata (newdata_o[s]),
            .irq     (irq_o[s])
        );
    end
endmodule

// File: rtl/rxs_mbox_status_chk.sv
module rxs_mbox_status_chk
    import rxs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frm_start,
    input logic              frm_end,
    input logic              frm_err,
    input logic              frm_accept,
    input logic [SLOT_W-1:0] frm_slot,
    input logic              wr_done,
    input logic [SLOT_W-1:0] wr_slot,
    input logic              sw_we,
    input logic [2:0]        sw_sel,
    input logic [NSLOT-1:0]  sw_wdata,
    input logic [NSLOT-1:0]  req_o,
    input logic [NSLOT-1:0]  storing_o,
    input logic [NSLOT-1:0]  newdata_o,
    input logic [NSLOT-1:0]  irq_o,
    input logic              receiving_o,
    input logic              success_o,
    input logic [SLOT_W-1:0] last_slot_o
);
    AST_RX_START: assert property (@(posedge clk) disable iff (rst)
        (frm_start && !frm_end && !frm_err) |=> receiving_o);                  // R2

    AST_RX_STOP: assert property (@(posedge clk) disable iff (rst)
        (frm_end || frm_err) |=> !receiving_o);                                // R2

    AST_COMPLETE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (frm_end && !frm_err && frm_accept && req_o[frm_slot])
        |=> (storing_o[$past(frm_slot)] && newdata_o[$past(frm_slot)] && success_o)); // R3

    AST_STORE_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
        ((storing_o & ~$past(storing_o) & ~$past(req_o)) == '0));               // R4

    AST_RELEASE_PUBLISH: assert property (@(posedge clk) disable iff (rst)
        (wr_done && storing_o[wr_slot])
        |=> (irq_o[$past(wr_slot)] && last_slot_o == $past(wr_slot)));          // R5

    AST_SLOTNUM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_done && storing_o[wr_slot]) |=> $stable(last_slot_o));            // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(sw_we && sw_sel == SEL_IRQ_CLR) |=> ((~irq_o & $past(irq_o)) == '0)); // R7

    AST_SUCC_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(sw_we && sw_sel == SEL_STAT && !sw_wdata[0]) |=> !$fell(success_o));  // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (req_o == '0 && storing_o == '0 && newdata_o == '0 && irq_o == '0
                 && !receiving_o && !success_o && last_slot_o == '0));          // R9
endmodule

bind rxs_mbox_status rxs_mbox_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frm_start   (frm_start),
    .frm_end     (frm_end),
    .frm_err     (frm_err),
    .frm_accept  (frm_accept),
    .frm_slot    (frm_slot),
    .wr_done     (wr_done),
    .wr_slot     (wr_slot),
    .sw_we       (sw_we),
    .sw_sel      (sw_sel),
    .sw_wdata    (sw_wdata),
    .req_o       (req_o),
    .storing_o   (storing_o),
    .newdata_o   (newdata_o),
    .irq_o       (irq_o),
    .receiving_o (receiving_o),
    .success_o   (success_o),
    .last_slot_o (last_slot_o)
);

// File: tb/sim_rxs_mbox_status.sv
module sim_rxs_mbox_status;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_start = 0, frm_end = 0, frm_err = 0, frm_accept = 0;
    logic [3:0]  frm_slot = 0, wr_slot = 0;
    logic        wr_done = 0, sw_we = 0;
    logic [2:0]  sw_sel = 0;
    logic [15:0] sw_wdata = 0;
    logic [15:0] req_o, storing_o, newdata_o, irq_o;
    logic        receiving_o, success_o;
    logic [3:0]  last_slot_o;

    int checks = 0;
    int fails  = 0;
    bit run_cmp = 0;

    // reference state
    bit [15:0] m_req, m_sto, m_new, m_irq;
    bit        m_rcv, m_suc;
    int        m_last;

    always #(CLK_P/2) clk = ~clk;

    rxs_mbox_status u0 (
        .clk(clk), .rst(rst),
        .frm_start(frm_start), .frm_end(frm_end), .frm_err(frm_err),
        .frm_accept(frm_accept), .frm_slot(frm_slot),
        .wr_done(wr_done), .wr_slot(wr_slot),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .req_o(req_o), .storing_o(storing_o), .newdata_o(newdata_o), .irq_o(irq_o),
        .receiving_o(receiving_o), .success_o(success_o), .last_slot_o(last_slot_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        bit [15:0] o_req, o_sto;
        bit        done_ok, rel_ok;
        int        fs, ws;
        if (rst) begin
            m_req = 0; m_sto = 0; m_new = 0; m_irq = 0;
            m_rcv = 0; m_suc = 0; m_last = 0;
        end else begin
            o_req = m_req; o_sto = m_sto;
            fs = frm_slot; ws = wr_slot;
            done_ok = frm_end && !frm_err && frm_accept && o_req[fs];
            rel_ok  = wr_done && o_sto[ws];
            if (sw_we) begin
                case (sw_sel)
                    3'd0: m_req = m_req | sw_wdata;
                    3'd1: m_req = m_req & ~sw_wdata;
                    3'd2: m_new = m_new & ~sw_wdata;
                    3'd3: m_irq = m_irq & ~sw_wdata;
                    3'd4: if (!sw_wdata[0]) m_suc = 0;
                    default: ;
                endcase
            end
            if (rel_ok) begin
                m_sto[ws] = 0; m_irq[ws] = 1; m_last = ws;
            end
            if (done_ok) begin
                m_sto[fs] = 1; m_new[fs] = 1; m_suc = 1;
            end
            if (frm_end || frm_err) m_rcv = 0;
            else if (frm_start)     m_rcv = 1;
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (run_cmp) begin
            chk("R1 req",        32'(req_o),       32'(m_req));
            chk("R2 receiving",  32'(receiving_o), 32'(m_rcv));
            chk("R3 storing",    32'(storing_o),   32'(m_sto));
            chk("R3 newdata",    32'(newdata_o),   32'(m_new));
            chk("R8 success",    32'(success_o),   32'(m_suc));
            chk("R5 irq",        32'(irq_o),       32'(m_irq));
            chk("R5 last_slot",  32'(last_slot_o), 32'(m_last));
        end
    end

    task automatic clr_in();
        frm_start = 0; frm_end = 0; frm_err = 0; frm_accept = 0; frm_slot = 0;
        wr_done = 0; wr_slot = 0; sw_we = 0; sw_sel = 0; sw_wdata = 0;
    endtask

    task automatic settle();
        @(negedge clk); clr_in();
    endtask

    task automatic swr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk); clr_in(); sw_we = 1; sw_sel = s; sw_wdata = d;
    endtask

    task automatic fstart();
        @(negedge clk); clr_in(); frm_start = 1;
    endtask

    task automatic fend(input int s, input bit acc, input bit err);
        @(negedge clk); clr_in(); frm_end = 1; frm_slot = 4'(s); frm_accept = acc; frm_err = err;
    endtask

    task automatic wdone(input int s);
        @(negedge clk); clr_in(); wr_done = 1; wr_slot = 4'(s);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clr_in();
        rst = 1;
        repeat (3) @(negedge clk);
        run_cmp = 1;
        // R9: reset state
        chk("R9 reset req",  32'(req_o), 0);
        chk("R9 reset irq",  32'(irq_o), 0);
        chk("R9 reset last", 32'(last_slot_o), 0);
        rst = 0;

        // R1: arm slots 3 and 15
        swr(3'd0, 16'h8008); settle();
        chk("R1 armed", 32'(req_o), 32'h8008);

        // R2, R3: accepted frame on slot 3
        fstart(); settle();
        chk("R2 receiving set", 32'(receiving_o), 1);
        fend(3, 1, 0); settle();
        chk("R2 receiving cleared", 32'(receiving_o), 0);
        chk("R3 storing slot3", 32'(storing_o), 32'h0008);
        chk("R3 newdata slot3", 32'(newdata_o), 32'h0008);
        chk("R3 success", 32'(success_o), 1);
        chk("R3 irq not yet", 32'(irq_o), 0);

        // R5: write done publishes
        wdone(3); settle();
        chk("R5 storing dropped", 32'(storing_o), 0);
        chk("R5 irq slot3", 32'(irq_o), 32'h0008);
        chk("R5 last slot", 32'(last_slot_o), 3);
        chk("R10 still armed", 32'(req_o), 32'h8008);

        // R4: unarmed, rejected and errored frames ignored
        fstart(); fend(5, 1, 0); settle();
        chk("R4 unarmed newdata", 32'(newdata_o), 32'h0008);
        fstart(); fend(15, 0, 0); settle();
        chk("R4 rejected storing", 32'(storing_o), 0);
        fstart(); fend(15, 1, 1); settle();
        chk("R4 errored storing", 32'(storing_o), 0);
        chk("R2 error clears receiving", 32'(receiving_o), 0);

        // R6: write done on idle slot
        wdone(7); settle();
        chk("R6 last unchanged", 32'(last_slot_o), 3);
        chk("R6 irq unchanged", 32'(irq_o), 32'h0008);

        // R7: hardware set beats W1C in the same cycle
        fstart();
        @(negedge clk); clr_in(); frm_end = 1; frm_accept = 1; frm_slot = 15;
        sw_we = 1; sw_sel = 3'd2; sw_wdata = 16'h8008;
        settle();
        chk("R7 newdata set wins", 32'(newdata_o), 32'h8000);
        wdone(15); settle();
        chk("R5 last slot 15", 32'(last_slot_o), 15);
        swr(3'd3, 16'h0008); settle();
        chk("R7 irq w1c", 32'(irq_o), 32'h8000);
        swr(3'd2, 16'h8000); settle();
        chk("R7 newdata w1c", 32'(newdata_o), 0);

        // R10: second reception on the same slot without re-arming
        fstart(); fend(3, 1, 0); settle();
        chk("R10 rearm not needed", 32'(newdata_o), 32'h0008);
        wdone(3); settle();

        // R8: success clear control
        swr(3'd4, 16'h0001); settle();
        chk("R8 write one no effect", 32'(success_o), 1);
        swr(3'd4, 16'h0000); settle();
        chk("R8 write zero clears", 32'(success_o), 0);

        // R1: disarm slot 3, then frame ignored
        swr(3'd1, 16'h0008); settle();
        chk("R1 disarmed", 32'(req_o), 32'h8000);
        fstart(); fend(3, 1, 0); settle();
        chk("R4 disarmed ignored", 32'(storing_o), 0);

        // mixed random traffic, checked by the model each cycle
        swr(3'd0, 16'hA5F3); settle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk); clr_in();
            frm_start  = ($urandom % 4) == 0;
            frm_end    = ($urandom % 3) == 0;
            frm_err    = ($urandom % 8) == 0;
            frm_accept = ($urandom % 4) != 0;
            frm_slot   = 4'($urandom);
            wr_done    = ($urandom % 2) == 0;
            wr_slot    = 4'($urandom);
            sw_we      = ($urandom % 5) == 0;
            sw_sel     = 3'($urandom % 6);
            sw_wdata   = 16'($urandom);
        end
        settle();

        // R9: reset in mid-run
        @(negedge clk); clr_in(); rst = 1;
        @(negedge clk); rst = 0;
        chk("R9 mid reset storing", 32'(storing_o), 0);
        chk("R9 mid reset newdata", 32'(newdata_o), 0);
        chk("R9 mid reset success", 32'(success_o), 0);
        settle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule